// File: doc/BRIEF.md
# Spread-spectrum modulation profile generator

This block drives the frequency-offset input of a PLL divider controller or a digitally controlled oscillator. It produces a signed offset that follows a triangle about zero, so the synthesized clock is swept evenly above and below its programmed average. The offset is a fraction of the nominal divide value, counted in parts per 65536. Two peak depths are available. An active-low enable turns the sweep on, and with that input at its default low level the block is spreading. When the sweep is switched off it is ramped back to zero instead of being cut off.

The block also takes two 2-bit band selects, one for the reference clock and one for the output clock. From these it reports the log2 ratio between the output and reference bands. When either select holds the reserved code it raises an error flag and forces the offset to zero. Every control input is brought into the clock domain through a two-stage synchronizer. A change of depth takes effect only when the sweep passes through zero, so the output frequency never jumps.

Top module: `ssm_gen`

## Requirements
- R1: After reset `ofs_o` is 0, `rng_bad_o` is 0 and `mult_exp_o` is 0. The synchronizers reset to enable low, depth 0 and both band codes 2'b11.
- R2: While `spread_en_ni` is 0 the offset sweeps and takes nonzero values. While it is 1 the offset settles at 0 and stays there.
- R3: The peak offset is exactly +410 and the trough exactly -410 with `width_sel_i`=0 (0.625 %). With `width_sel_i`=1 they are +1638 and -1638 (2.5 %). `ofs_o` is 16-bit two's complement.
- R4: The profile is a symmetric triangle with a period of `PERIOD_CYC` clocks (default 1000). It travels from +limit to -limit in exactly `PERIOD_CYC`/2 clocks. Starting from 0 after reset, it rises first.
- R5: The offset moves along a line of slope 2·limit/(`PERIOD_CYC`/2) per clock, with the fractional part carried from one clock to the next. Each clock step is therefore the floor or the ceiling of that slope.
- R6: A new `width_sel_i` value takes effect only in a clock where the exact swept position is zero. The first step at the new slope starts from an offset of 0.
- R7: When spreading is turned off, the offset moves toward 0 at the R5 slope of the active depth. It lands exactly on 0 without crossing it, and sweeping resumes upward from 0.
- R8: Band codes are 2'b01 (15–30 MHz), 2'b10 (30–60 MHz) and 2'b11 (60–120 MHz). `mult_exp_o` is the 3-bit two's-complement value out_code − in_code, so the output-to-reference ratio is 2^`mult_exp_o`.
- R9: Band code 2'b00 on either select sets `rng_bad_o` to 1, forces `ofs_o` to 0 and sets `mult_exp_o` to 0.
- R10: A change on any input reaches the outputs at the third rising clock edge after the change: two synchronizer stages and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spread_en_ni | input | 1 | Sweep enable, active low |
| width_sel_i | input | 1 | Depth select: 0 = ±0.625 %, 1 = ±2.5 % |
| in_rng_i | input | 2 | Reference band code |
| out_rng_i | input | 2 | Output band code |
| ofs_o | output | 16 | Signed offset, parts per 65536 of nominal divide |
| mult_exp_o | output | 3 | Signed log2 of output/reference band ratio |
| rng_bad_o | output | 1 | Reserved band code present |

## Verification
Every output is due at the third rising edge after the input change that causes it. The bench reference model passes its sampled inputs through two stages of delay, then applies the sweep arithmetic at that edge and updates the expected offset. DUT and model are compared at each falling edge, half a clock away from the edges where the outputs change. Directed checks count edges in the same way: a reserved code must not yet be flagged after two edges and must be flagged after the third. The peak, trough, timing from peak to trough, ramp steps and the depth switch at zero are measured on the sampled offset sequence.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  localparam int RNG_W  = 2;
  localparam int EXP_W  = RNG_W + 1;
  localparam int SYNC_W = 2 + 2 * RNG_W;
  localparam logic [RNG_W-1:0] RNG_RSVD = '0;

  typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} dir_e;
endpackage

// File: rtl/ssm_sync.sv
module ssm_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/ssm_rng_dec.sv
module ssm_rng_dec
  import ssm_pkg::*;
(
  input  logic                    [RNG_W-1:0] in_code_i,
  input  logic                    [RNG_W-1:0] out_code_i,
  output logic                                bad_o,
  output logic signed             [EXP_W-1:0] exp_o
);
  always_comb begin
    bad_o = (in_code_i == RNG_RSVD) || (out_code_i == RNG_RSVD);
    exp_o = bad_o ? '0 : ($signed({1'b0, out_code_i}) - $signed({1'b0, in_code_i}));
  end
endmodule

// File: rtl/ssm_tri_core.sv
module ssm_tri_core
  import ssm_pkg::*;
#(
  parameter int PERIOD_CYC = 1000,
  parameter int OFS_W      = 16,
  parameter int NARROW_LIM = 410,
  parameter int WIDE_LIM   = 1638
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic                    wsel_i,
  input  logic                    bad_i,
  output logic signed [OFS_W-1:0] ofs_o
);
  localparam int HALF  = PERIOD_CYC / 2;
  localparam int ERR_W = $clog2(HALF) + 2;
  localparam int Q_N   = (2 * NARROW_LIM) / HALF;
  localparam int R_N   = (2 * NARROW_LIM) % HALF;
  localparam int Q_W   = (2 * WIDE_LIM) / HALF;
  localparam int R_W   = (2 * WIDE_LIM) % HALF;
  localparam int STEP_MAX = Q_W + 1;

  localparam logic signed [ERR_W-1:0] HALF_E = ERR_W'(HALF);
  localparam logic signed [OFS_W-1:0] LIM_N  = OFS_W'(NARROW_LIM);
  localparam logic signed [OFS_W-1:0] LIM_W  = OFS_W'(WIDE_LIM);

  logic signed [OFS_W-1:0] ofs_q, ofs_d;
  logic signed [ERR_W-1:0] err_q, err_d;
  dir_e                    dir_q, dir_d;
  logic                    w_act_q, w_eff, p_zero;

  logic signed [OFS_W-1:0] lim, q_sel, ofs_up, ofs_dn, cy_up, cy_dn;
  logic signed [ERR_W-1:0] r_sel, err_up_raw, err_dn_raw, err_up, err_dn;
  logic                    carry, borrow;

  assign p_zero = (ofs_q == '0) && (err_q == '0);
  assign w_eff  = p_zero ? wsel_i : w_act_q;

  always_comb begin
    lim        = w_eff ? LIM_W : LIM_N;
    q_sel      = w_eff ? OFS_W'(Q_W) : OFS_W'(Q_N);
    r_sel      = w_eff ? ERR_W'(R_W) : ERR_W'(R_N);
    err_up_raw = err_q + r_sel;
    carry      = err_up_raw >= HALF_E;
    err_up     = carry ? err_up_raw - HALF_E : err_up_raw;
    cy_up      = {{(OFS_W-1){1'b0}}, carry};
    ofs_up     = ofs_q + q_sel + cy_up;
    err_dn_raw = err_q - r_sel;
    borrow     = err_dn_raw < 0;
    err_dn     = borrow ? err_dn_raw + HALF_E : err_dn_raw;
    cy_dn      = {{(OFS_W-1){1'b0}}, borrow};
    ofs_dn     = ofs_q - q_sel - cy_dn;
  end

  always_comb begin
    ofs_d = ofs_q;
    err_d = err_q;
    dir_d = dir_q;
    if (bad_i) begin
      ofs_d = '0;
      err_d = '0;
      dir_d = DIR_UP;
    end else if (run_i) begin
      if (dir_q == DIR_UP) begin
        if (ofs_up >= lim) begin
          ofs_d = lim;
          err_d = '0;
          dir_d = DIR_DN;
        end else begin
          ofs_d = ofs_up;
          err_d = err_up;
        end
      end else begin
        if ((ofs_dn < -lim) || ((ofs_dn == -lim) && (err_dn == '0))) begin
          ofs_d = -lim;
          err_d = '0;
          dir_d = DIR_UP;
        end else begin
          ofs_d = ofs_dn;
          err_d = err_dn;
        end
      end
    end else if (ofs_q < 0) begin
      // ramp up toward zero
      dir_d = DIR_UP;
      if (ofs_up >= 0) begin
        ofs_d = '0;
        err_d = '0;
      end else begin
        ofs_d = ofs_up;
        err_d = err_up;
      end
    end else if (!p_zero) begin
      // ramp down toward zero
      if ((ofs_dn < 0) || ((ofs_dn == 0) && (err_dn == '0))) begin
        ofs_d = '0;
        err_d = '0;
        dir_d = DIR_UP;
      end else begin
        ofs_d = ofs_dn;
        err_d = err_dn;
        dir_d = DIR_DN;
      end
    end else begin
      dir_d = DIR_UP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_q   <= '0;
      err_q   <= '0;
      dir_q   <= DIR_UP;
      w_act_q <= 1'b0;
    end else begin
      ofs_q   <= ofs_d;
      err_q   <= err_d;
      dir_q   <= dir_d;
      w_act_q <= w_eff;
    end
  end

  assign ofs_o = ofs_q;

  // R3
  lim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_act_q ? (ofs_q <= LIM_W && ofs_q >= -LIM_W) : (ofs_q <= LIM_N && ofs_q >= -LIM_N));

  // R5
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad_i |=> ((int'(ofs_q) - int'($past(ofs_q))) <= STEP_MAX &&
                (int'(ofs_q) - int'($past(ofs_q))) >= -STEP_MAX));

  // R7
  ramp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !bad_i && ofs_q > 0) |=> (ofs_q >= 0 && ofs_q <= $past(ofs_q)));

  // R6
  wchg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(w_act_q) |-> ($past(ofs_q) == '0));
endmodule

// File: rtl/ssm_gen.sv
module ssm_gen
  import ssm_pkg::*;
#(
  parameter int PERIOD_CYC = 1000,
  parameter int OFS_W      = 16,
  parameter int NARROW_LIM = 410,
  parameter int WIDE_LIM   = 1638
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    spread_en_ni,
  input  logic                    width_sel_i,
  input  logic [RNG_W-1:0]        in_rng_i,
  input  logic [RNG_W-1:0]        out_rng_i,
  output logic signed [OFS_W-1:0] ofs_o,
  output logic [EXP_W-1:0]        mult_exp_o,
  output logic                    rng_bad_o
);
  localparam logic [SYNC_W-1:0] SYNC_RST = {1'b0, 1'b0, {RNG_W{1'b1}}, {RNG_W{1'b1}}};

  logic [SYNC_W-1:0]       raw, syn;
  logic                    en_n_s, w_s, bad_c;
  logic [RNG_W-1:0]        in_s, out_s;
  logic signed [EXP_W-1:0] exp_c;
  logic                    bad_q;
  logic [EXP_W-1:0]        exp_q;

  assign raw = {spread_en_ni, width_sel_i, in_rng_i, out_rng_i};

  ssm_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign {en_n_s, w_s, in_s, out_s} = syn;

  ssm_rng_dec u_dec (
    .in_code_i (in_s),
    .out_code_i(out_s),
    .bad_o     (bad_c),
    .exp_o     (exp_c)
  );

  ssm_tri_core #(
    .PERIOD_CYC(PERIOD_CYC),
    .OFS_W     (OFS_W),
    .NARROW_LIM(NARROW_LIM),
    .WIDE_LIM  (WIDE_LIM)
  ) u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (!en_n_s),
    .wsel_i(w_s),
    .bad_i (bad_c),
    .ofs_o (ofs_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bad_q <= 1'b0;
      exp_q <= '0;
    end else begin
      bad_q <= bad_c;
      exp_q <= exp_c;
    end
  end

  assign rng_bad_o  = bad_q;
  assign mult_exp_o = exp_q;

  // R9
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rng_bad_o |-> (ofs_o == '0 && mult_exp_o == '0));
endmodule

// File: tb/sim_ssm_gen.sv
`timescale 1ns/1ps
module sim_ssm_gen;
  localparam int HALF = 500;
  localparam int LN   = 410;
  localparam int LW   = 1638;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              en_n = 1'b0;
  logic              wsel = 1'b0;
  logic [1:0]        ir = 2'b11;
  logic [1:0]        orr = 2'b11;
  logic signed [15:0] ofs;
  logic [2:0]        mexp;
  logic              bad;

  int n_chk = 0, n_fail = 0, cyc_cnt = 0;
  bit cmp_on = 0, done = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  ssm_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .spread_en_ni(en_n), .width_sel_i(wsel),
    .in_rng_i(ir), .out_rng_i(orr), .ofs_o(ofs), .mult_exp_o(mexp), .rng_bad_o(bad)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int fdiv(int p, int h);
    if (p >= 0) return p / h;
    return -((-p + h - 1) / h);
  endfunction

  // reference model: scaled position P = offset * HALF + fraction
  int P, m_dir, m_act, m_bad, m_mult;
  int s1_en, s1_w, s1_ir, s1_or, s2_en, s2_w, s2_ir, s2_or;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      P = 0; m_dir = 1; m_act = 0; m_bad = 0; m_mult = 0;
      s1_en = 0; s1_w = 0; s1_ir = 3; s1_or = 3;
      s2_en = 0; s2_w = 0; s2_ir = 3; s2_or = 3;
    end else begin
      int lim, d, rb;
      rb = (s2_ir == 0) || (s2_or == 0);
      if (P == 0) m_act = s2_w;
      lim = m_act ? LW : LN;
      d = 2 * lim;
      if (rb) begin
        P = 0; m_dir = 1;
      end else if (s2_en == 0) begin
        if (m_dir == 1) begin
          P += d;
          if (P >= lim * HALF) begin P = lim * HALF; m_dir = 0; end
        end else begin
          P -= d;
          if (P <= -lim * HALF) begin P = -lim * HALF; m_dir = 1; end
        end
      end else if (P < 0) begin
        P += d; m_dir = 1;
        if (P >= 0) P = 0;
      end else if (P > 0) begin
        P -= d;
        if (P <= 0) begin P = 0; m_dir = 1; end
        else m_dir = 0;
      end else m_dir = 1;
      m_bad = rb;
      m_mult = rb ? 0 : (s2_or - s2_ir);
      s2_en = s1_en; s2_w = s1_w; s2_ir = s1_ir; s2_or = s1_or;
      s1_en = en_n; s1_w = wsel; s1_ir = ir; s1_or = orr;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(cur_req, "ofs vs model", int'(ofs), fdiv(P, HALF));
      chk(cur_req, "rng_bad vs model", int'(bad), m_bad);
      chk(cur_req, "mult_exp vs model", int'($signed(mexp)), m_mult);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc_cnt);
      finish_run();
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int vmax, vmin, v, prev, t_pos, t_neg;
    bit seen, bad_ramp;
    cyc(3);
    rst_ni = 1'b1;
    // R1 reset state, sampled before any active edge
    chk("R1", "ofs after reset", int'(ofs), 0);
    chk("R1", "rng_bad after reset", int'(bad), 0);
    chk("R1", "mult_exp after reset", int'($signed(mexp)), 0);
    cmp_on = 1;

    // R4 narrow triangle timing and limits
    cur_req = "R4";
    vmax = -100000; vmin = 100000; t_pos = -1; t_neg = -1;
    for (int i = 1; i <= 1200; i++) begin
      cyc(1);
      v = int'(ofs);
      if (v > vmax) vmax = v;
      if (v < vmin) vmin = v;
      if (v == LN && t_pos < 0) t_pos = i;
      if (v == -LN && t_pos >= 0 && t_neg < 0) t_neg = i;
    end
    chk("R3", "narrow peak", vmax, LN);
    chk("R3", "narrow trough", vmin, -LN);
    chk("R4", "first peak cycle", t_pos, 250);
    chk("R4", "peak to trough cycles", t_neg - t_pos, HALF);

    // R6 depth change only at zero
    cur_req = "R6";
    wsel = 1'b1;
    seen = 0; vmax = -100000; vmin = 100000;
    prev = int'(ofs);
    for (int i = 0; i < 1500; i++) begin
      cyc(1);
      v = int'(ofs);
      if (!seen && (v - prev > 2 || prev - v > 2)) begin
        seen = 1;
        chk("R6", "offset before first wide step", prev, 0);
      end
      if (v > vmax) vmax = v;
      if (v < vmin) vmin = v;
      prev = v;
    end
    chk("R6", "wide step observed", int'(seen), 1);
    chk("R3", "wide peak", vmax, LW);
    chk("R3", "wide trough", vmin, -LW);

    // R7 ramp to zero on disable
    cur_req = "R7";
    for (int i = 0; i < 2000 && int'(ofs) <= 800; i++) cyc(1);
    en_n = 1'b1;
    cyc(3);
    bad_ramp = 0;
    prev = int'(ofs);
    for (int i = 0; i < 400; i++) begin
      cyc(1);
      v = int'(ofs);
      if (v < 0 || v > prev) bad_ramp = 1;
      if (v != 0 && (prev - v) != 6 && (prev - v) != 7) bad_ramp = 1;
      if (v == 0 && prev > 7) bad_ramp = 1;
      prev = v;
    end
    chk("R7", "ramp steps 6/7 without overshoot", int'(bad_ramp), 0);
    chk("R2", "offset held at zero while disabled", int'(ofs), 0);
    cyc(50);
    chk("R2", "still zero after 50 cycles", int'(ofs), 0);

    cur_req = "R2";
    en_n = 1'b0;
    cyc(10);
    chk("R2", "sweep resumed upward", int'(ofs > 0), 1);

    // R8 band decode
    cur_req = "R8";
    for (int a = 1; a <= 3; a++) begin
      for (int b = 1; b <= 3; b++) begin
        ir = 2'(a); orr = 2'(b);
        cyc(3);
        chk("R8", "mult_exp", int'($signed(mexp)), b - a);
        chk("R8", "no flag on valid codes", int'(bad), 0);
      end
    end

    // R10 latency, R9 reserved code
    cur_req = "R10";
    ir = 2'b00;
    cyc(2);
    chk("R10", "flag not yet after two edges", int'(bad), 0);
    cyc(1);
    chk("R10", "flag after third edge", int'(bad), 1);
    chk("R9", "offset forced zero", int'(ofs), 0);
    cur_req = "R9";
    cyc(20);
    chk("R9", "offset stays zero", int'(ofs), 0);
    ir = 2'b01; orr = 2'b00;
    cyc(5);
    chk("R9", "flag on output code 00", int'(bad), 1);
    chk("R9", "mult_exp zero on reserved", int'($signed(mexp)), 0);
    orr = 2'b11;
    cyc(30);
    chk("R9", "flag clears", int'(bad), 0);
    finish_run();
  end
endmodule